// File: doc/BRIEF.md
# Byte/Word/Flag Data Memory Accessor

This block is the data-memory access path of a small DSP-style core. The memory holds 17-bit locations: sixteen data bits plus one hidden flag bit. A request names a mode, a byte address taken from an index register, an optional element count for strings, and whether the index should be post-modified. The accessor reads or writes single bytes, single words, runs of bytes or words, or a lone flag bit.

Read data reaches the accumulator zero-extended. Every read also copies the flag of the location it touched into a status TAG bit. When the access completes, the block returns the index register's new value. String transfers run one element per clock from the starting address upward. A busy/done pair and a per-read valid strobe let the core follow progress.

Top module: `dmem_accessor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy, done, rd_valid, acc_out, tag and index_out are all zero, and every memory location, including its flag bit, reads as zero.
- R2: A word access (op code 2, or 3 for strings) ignores bit 0 of the byte address. Byte addresses 2w and 2w+1 both reach word w, and the 16-bit word is returned on acc_out.
- R3: A byte read (op code 0, or 1 for strings) returns bits 15:8 of the word for an even byte address and bits 7:0 for an odd one, in acc_out[7:0], with acc_out[15:8] zero.
- R4: A byte write stores wr_data[7:0] into the addressed byte only; the other byte and the flag bit keep their values. A word write replaces bits 15:0 with wr_data and leaves the flag bit unchanged.
- R5: Every read element (byte, word or flag) loads the flag bit of its word into tag; writes never change tag.
- R6: String modes (codes 1 and 3) handle str_len elements (0 is taken as 1), one per clock, at ascending addresses: byte strings advance the byte address by 1 and word strings by 2.
- R7: After a string read, tag equals the flag of the last element read.
- R8: When the access finishes, index_out becomes index_in plus 1 per byte element or 2 per word element if post_mod is 1, and index_in unchanged if post_mod is 0. A flag access always returns index_in.
- R9: A flag access (op code 4; codes 5 to 7 behave the same) treats index_in as a word index and ignores str_len. A read gives the flag in acc_out[0] with the other bits zero. A write sets the flag bit to wr_data[0] and leaves the data bits unchanged.
- R10: The first element is handled on the clock edge that accepts start. busy is high after each element that is not the last. done and the results of a read element (rd_valid, acc_out, tag) appear on the cycle after that element's edge. done pulses once per access.
- R11: start is ignored while busy is high; the running access finishes unchanged and no other memory location is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 3 | Mode: 0 byte, 1 byte string, 2 word, 3 word string, 4 flag |
| write | input | 1 | 1 = write, 0 = read |
| post_mod | input | 1 | Enable post-modification of the index |
| index_in | input | 16 | Byte address (word index in flag mode) |
| str_len | input | LEN_W | Element count for string modes |
| wr_data | input | 16 | Write data, sampled on each element's edge |
| busy | output | 1 | More elements of the current string remain |
| done | output | 1 | One-cycle pulse after the last element |
| rd_valid | output | 1 | One-cycle pulse after each read element |
| acc_out | output | 16 | Zero-extended read data |
| tag | output | 1 | Status TAG bit: flag of the last word read |
| index_out | output | 16 | Post-modified index value |

## Verification
Some properties are checked on every cycle: acc_out and tag move only with a read strobe, index_out moves only with done, done never appears while busy is high, and byte and flag reads leave the unused high bits of acc_out clear. Other behaviour only the bench scenarios can show. This covers byte-lane selection and merging, word alignment of odd addresses, which flag a string leaves in tag, the final index for each mode and post-modify setting, and the fact that a start pulsed during a string changes neither the results nor the stored flags.

// File: rtl/dmem_pkg.sv
// Shared mode encoding and per-mode helpers for the data memory accessor.
package dmem_pkg;

    typedef enum logic [2:0] {
        M_BYTE     = 3'd0,
        M_BYTE_STR = 3'd1,
        M_WORD     = 3'd2,
        M_WORD_STR = 3'd3,
        M_FLAG     = 3'd4
    } acc_mode_e;

    // True for the two modes that run over several elements.
    function automatic logic is_string(acc_mode_e m);
        return (m == M_BYTE_STR) || (m == M_WORD_STR);
    endfunction

    // True for the byte-lane modes.
    function automatic logic is_byte(acc_mode_e m);
        return (m == M_BYTE) || (m == M_BYTE_STR);
    endfunction

    // Byte-address advance per element: 1 for bytes, 2 for words, 0 for flags.
    function automatic logic [1:0] step_of(acc_mode_e m);
        case (m)
            M_BYTE, M_BYTE_STR: return 2'd1;
            M_WORD, M_WORD_STR: return 2'd2;
            default:            return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dmem_store.sv
// Word store: 2**WORD_ADDR_W locations of 17 bits (flag in bit 16).
// One combinational read port and one write port share a single index.
// Write enables cover the high byte, the low byte and the flag separately.
// Assumes the caller keeps indices inside the array (power-of-two depth).
module dmem_store #(
    parameter int WORD_ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_ADDR_W-1:0] idx,
    input  logic                   we_hi,
    input  logic                   we_lo,
    input  logic                   we_flag,
    input  logic [16:0]            wr_word,
    output logic [16:0]            rd_word
);
    localparam int WORDS = 1 << WORD_ADDR_W;

    logic [16:0] mem_q [WORDS];

    // Clear on reset, then apply per-field writes at the shared index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (we_hi)   mem_q[idx][15:8] <= wr_word[15:8];
            if (we_lo)   mem_q[idx][7:0]  <= wr_word[7:0];
            if (we_flag) mem_q[idx][16]   <= wr_word[16];
        end
    end

    assign rd_word = mem_q[idx];

endmodule

// File: rtl/dmem_lane.sv
// Lane logic: picks the read value for the mode (high/low byte, whole
// word, or flag) and builds the write word plus per-field enables.
// Big-endian bytes: an even byte address maps to bits 15:8.
// Purely combinational; the caller gates the enables with its fire strobe.
module dmem_lane
    import dmem_pkg::*;
(
    input  acc_mode_e   mode,
    input  logic        byte_odd,
    input  logic        is_write,
    input  logic [16:0] word_in,
    input  logic [15:0] wdata,
    output logic [15:0] rd_val,
    output logic        rd_flag,
    output logic        we_hi,
    output logic        we_lo,
    output logic        we_flag,
    output logic [16:0] wr_word
);
    // Select read data and write fields for the current mode.
    always_comb begin
        rd_flag = word_in[16];
        rd_val  = '0;
        wr_word = word_in;
        we_hi   = 1'b0;
        we_lo   = 1'b0;
        we_flag = 1'b0;
        case (mode)
            M_BYTE, M_BYTE_STR: begin
                rd_val        = {8'h00, (byte_odd ? word_in[7:0] : word_in[15:8])};
                wr_word[15:8] = wdata[7:0];
                wr_word[7:0]  = wdata[7:0];
                we_hi         = is_write & ~byte_odd;
                we_lo         = is_write & byte_odd;
            end
            M_WORD, M_WORD_STR: begin
                rd_val        = word_in[15:0];
                wr_word[15:0] = wdata;
                we_hi         = is_write;
                we_lo         = is_write;
            end
            default: begin
                rd_val      = {15'd0, word_in[16]};
                wr_word[16] = wdata[0];
                we_flag     = is_write;
            end
        endcase
    end

endmodule

// File: rtl/dmem_seq.sv
// Element sequencer: handles the first element on the edge that accepts
// start, then one element per clock until the count runs out. Produces
// the current byte address and the address after it.
// Assumes step is held constant for the whole run by the caller.
module dmem_seq #(
    parameter int AW    = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             str_mode,
    input  logic [LEN_W-1:0] len,
    input  logic [AW-1:0]    addr_in,
    input  logic [1:0]       step,
    output logic             fire,
    output logic             first,
    output logic             last,
    output logic             busy,
    output logic [AW-1:0]    cur_addr,
    output logic [AW-1:0]    next_addr
);
    logic             busy_q;
    logic [AW-1:0]    ptr_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] len_eff;

    // Element count of a new request: strings use len (0 counts as 1).
    always_comb begin
        if (str_mode && (len != '0)) len_eff = len;
        else                         len_eff = LEN_W'(1);
    end

    assign first     = start & ~busy_q;
    assign fire      = busy_q | start;
    assign cur_addr  = busy_q ? ptr_q : addr_in;
    assign next_addr = cur_addr + AW'(step);
    assign last      = busy_q ? (left_q == LEN_W'(1)) : (len_eff == LEN_W'(1));
    assign busy      = busy_q;

    // Advance pointer and remaining count on every element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
            left_q <= '0;
        end else if (fire) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                busy_q <= 1'b1;
                ptr_q  <= next_addr;
                left_q <= busy_q ? (left_q - LEN_W'(1)) : (len_eff - LEN_W'(1));
            end
        end
    end

endmodule

// File: rtl/dmem_accessor.sv
// Data memory accessor top: byte, word, string and flag accesses to a
// 17-bit-per-location store, with TAG capture and index post-modification.
// Assumes addresses stay inside the store; the request fields are latched
// at acceptance, and wr_data is sampled on every element's edge.
module dmem_accessor
    import dmem_pkg::*;
#(
    parameter int WORD_ADDR_W = 6,
    parameter int LEN_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             write,
    input  logic             post_mod,
    input  logic [15:0]      index_in,
    input  logic [LEN_W-1:0] str_len,
    input  logic [15:0]      wr_data,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [15:0]      acc_out,
    output logic             tag,
    output logic [15:0]      index_out
);
    localparam int AW = 16;

    acc_mode_e            op_mode, mode_q, mode_eff;
    logic                 wr_q, pm_q, wr_eff, pm_eff;
    logic [AW-1:0]        base_q, base_eff;
    logic                 seq_fire, seq_first, seq_last, seq_busy;
    logic [AW-1:0]        cur_addr, next_addr;
    logic [WORD_ADDR_W-1:0] word_idx;
    logic [16:0]          rd_word, wr_word;
    logic [15:0]          lane_val;
    logic                 lane_flag, we_hi, we_lo, we_flag;
    logic                 byte_rd_now, flag_rd_now;

    // Map reserved codes onto the flag mode.
    always_comb begin
        if (op > 3'd4) op_mode = M_FLAG;
        else           op_mode = acc_mode_e'(op);
    end

    // Latch the request context when a new access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_BYTE;
            wr_q   <= 1'b0;
            pm_q   <= 1'b0;
            base_q <= '0;
        end else if (seq_first) begin
            mode_q <= op_mode;
            wr_q   <= write;
            pm_q   <= post_mod;
            base_q <= index_in;
        end
    end

    assign mode_eff = seq_busy ? mode_q : op_mode;
    assign wr_eff   = seq_busy ? wr_q   : write;
    assign pm_eff   = seq_busy ? pm_q   : post_mod;
    assign base_eff = seq_busy ? base_q : index_in;

    dmem_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .str_mode  (is_string(op_mode)),
        .len       (str_len),
        .addr_in   (index_in),
        .step      (step_of(mode_eff)),
        .fire      (seq_fire),
        .first     (seq_first),
        .last      (seq_last),
        .busy      (seq_busy),
        .cur_addr  (cur_addr),
        .next_addr (next_addr)
    );

    // Word index: flag mode uses the address as-is, others drop byte bit 0.
    always_comb begin
        if (mode_eff == M_FLAG) word_idx = cur_addr[WORD_ADDR_W-1:0];
        else                    word_idx = cur_addr[WORD_ADDR_W:1];
    end

    dmem_lane u_lane (
        .mode     (mode_eff),
        .byte_odd (cur_addr[0]),
        .is_write (wr_eff),
        .word_in  (rd_word),
        .wdata    (wr_data),
        .rd_val   (lane_val),
        .rd_flag  (lane_flag),
        .we_hi    (we_hi),
        .we_lo    (we_lo),
        .we_flag  (we_flag),
        .wr_word  (wr_word)
    );

    dmem_store #(.WORD_ADDR_W(WORD_ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (word_idx),
        .we_hi   (seq_fire & we_hi),
        .we_lo   (seq_fire & we_lo),
        .we_flag (seq_fire & we_flag),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    assign byte_rd_now = seq_fire & ~wr_eff & is_byte(mode_eff);
    assign flag_rd_now = seq_fire & ~wr_eff & (mode_eff == M_FLAG);

    // Register read results, completion pulse and the final index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            rd_valid  <= 1'b0;
            acc_out   <= '0;
            tag       <= 1'b0;
            index_out <= '0;
        end else begin
            done     <= seq_fire & seq_last;
            rd_valid <= seq_fire & ~wr_eff;
            if (seq_fire && !wr_eff) begin
                acc_out <= lane_val;
                tag     <= lane_flag;
            end
            if (seq_fire && seq_last) begin
                index_out <= pm_eff ? next_addr : base_eff;
            end
        end
    end

    assign busy = seq_busy;

endmodule

// File: rtl/dmem_accessor_chk.sv
// Checker for dmem_accessor: cycle-level relations between outputs and
// the internal element strobes. Attached with the bind below.
module dmem_accessor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        rd_valid,
    input logic [15:0] acc_out,
    input logic        tag,
    input logic [15:0] index_out,
    input logic        seq_fire,
    input logic        seq_last,
    input logic        byte_rd_now,
    input logic        flag_rd_now
);
    // R5: tag moves only with a read element
    assert_tag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(tag));

    // R10: acc_out moves only with a read element
    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(acc_out));

    // R10: done is never seen together with busy
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: the last element is followed by done
    assert_last_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fire && seq_last) |=> done);

    // R8: index_out changes only when an access completes
    assert_index_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(index_out));

    // R3: byte reads keep the upper accumulator byte clear
    assert_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rd_now |=> (acc_out[15:8] == 8'h00));

    // R9: flag reads keep acc_out[15:1] clear
    assert_flag_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_now |=> (acc_out[15:1] == 15'd0));

endmodule

bind dmem_accessor dmem_accessor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .rd_valid    (rd_valid),
    .acc_out     (acc_out),
    .tag         (tag),
    .index_out   (index_out),
    .seq_fire    (seq_fire),
    .seq_last    (seq_last),
    .byte_rd_now (byte_rd_now),
    .flag_rd_now (flag_rd_now)
);

// File: tb/sim_dmem_accessor.sv
// Scoreboard bench: the driver task models expected reads into queues,
// the monitor pops them as rd_valid pulses.
module sim_dmem_accessor;
    localparam int CLK_PERIOD = 10;
    localparam int WAW = 6;
    localparam int LW  = 8;
    localparam logic [2:0] OP_B = 3'd0, OP_BS = 3'd1, OP_W = 3'd2, OP_WS = 3'd3, OP_F = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic write = 1'b0;
    logic post_mod = 1'b0;
    logic [15:0] index_in = '0;
    logic [LW-1:0] str_len = '0;
    logic [15:0] wr_data = '0;
    logic busy, done, rd_valid, tag;
    logic [15:0] acc_out, index_out;

    int checks = 0;
    int errors = 0;
    logic [16:0] model [1 << WAW];
    logic exp_tag = 1'b0;
    logic [15:0] dq [16];
    logic [15:0] q_acc [$];
    logic        q_tag [$];
    string       q_req [$];

    dmem_accessor #(.WORD_ADDR_W(WAW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .write(write),
        .post_mod(post_mod), .index_in(index_in), .str_len(str_len),
        .wr_data(wr_data), .busy(busy), .done(done), .rd_valid(rd_valid),
        .acc_out(acc_out), .tag(tag), .index_out(index_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each read strobe against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_acc.size() == 0) begin
                chk(1'b0, "R10 unexpected rd_valid", 32'(acc_out), 32'hFFFF_FFFF);
            end else begin
                automatic logic [15:0] ea = q_acc.pop_front();
                automatic logic        et = q_tag.pop_front();
                automatic string       rq = q_req.pop_front();
                chk(acc_out == ea, {rq, " acc"}, 32'(acc_out), 32'(ea));
                chk(tag == et, {rq, " tag"}, 32'(tag), 32'(et));
            end
        end
    end

    // Driver: compute expectations, run the access, check handshake and index.
    task automatic do_op(input logic [2:0] m, input logic wr, input logic pm,
                         input logic [15:0] idx, input int len, input logic noise,
                         input string req);
        int n;
        int stp;
        logic [15:0] a;
        logic [15:0] exp_idx;
        n   = ((m == OP_BS || m == OP_WS) && len != 0) ? len : 1;
        stp = (m == OP_B || m == OP_BS) ? 1 : ((m == OP_W || m == OP_WS) ? 2 : 0);
        for (int k = 0; k < n; k++) begin
            a = idx + 16'(k * stp);
            if (m == OP_F) begin
                if (wr) model[a[WAW-1:0]][16] = dq[k][0];
                else begin
                    q_acc.push_back({15'd0, model[a[WAW-1:0]][16]});
                    q_tag.push_back(model[a[WAW-1:0]][16]);
                    q_req.push_back(req);
                    exp_tag = model[a[WAW-1:0]][16];
                end
            end else if (stp == 1) begin
                if (wr) begin
                    if (a[0]) model[a[WAW:1]][7:0] = dq[k][7:0];
                    else      model[a[WAW:1]][15:8] = dq[k][7:0];
                end else begin
                    q_acc.push_back(a[0] ? {8'h00, model[a[WAW:1]][7:0]} : {8'h00, model[a[WAW:1]][15:8]});
                    q_tag.push_back(model[a[WAW:1]][16]);
                    q_req.push_back(req);
                    exp_tag = model[a[WAW:1]][16];
                end
            end else begin
                if (wr) model[a[WAW:1]][15:0] = dq[k];
                else begin
                    q_acc.push_back(model[a[WAW:1]][15:0]);
                    q_tag.push_back(model[a[WAW:1]][16]);
                    q_req.push_back(req);
                    exp_tag = model[a[WAW:1]][16];
                end
            end
        end
        exp_idx = (pm && stp != 0) ? idx + 16'(n * stp) : idx;

        @(negedge clk);
        start = 1'b1; op = m; write = wr; post_mod = pm; index_in = idx;
        str_len = LW'(len); wr_data = dq[0];
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (noise && k < n) begin
                start = 1'b1; op = OP_F; write = 1'b1; index_in = 16'd0; wr_data = 16'd1;
            end else begin
                start = 1'b0;
                if (k < n) wr_data = dq[k];
            end
            chk(busy == (k < n), {req, " R10 busy"}, 32'(busy), 32'(k < n));
            chk(done == (k == n), {req, " R10 done"}, 32'(done), 32'(k == n));
        end
        start = 1'b0;
        chk(index_out == exp_idx, {req, " R8 index_out"}, 32'(index_out), 32'(exp_idx));
        chk(tag == exp_tag, {req, " R5 tag after access"}, 32'(tag), 32'(exp_tag));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << WAW); i++) model[i] = '0;
        for (int i = 0; i < 16; i++) dq[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every output
        chk(busy == 0 && done == 0 && rd_valid == 0, "R1 handshake reset", {busy, done, rd_valid}, 0);
        chk(acc_out == 0 && tag == 0, "R1 acc/tag reset", {acc_out, tag}, 0);
        chk(index_out == 0, "R1 index reset", 32'(index_out), 0);
        // R1: memory cleared
        do_op(OP_W, 0, 0, 16'd10, 1, 0, "R1 cleared word");

        // R2: word index 4 lives at byte 8; odd address 1 aligns to word 0
        dq[0] = 16'h1122; do_op(OP_W, 1, 0, 16'd8, 1, 0, "R2 write word4");
        dq[0] = 16'h1234; do_op(OP_W, 1, 1, 16'd1, 1, 0, "R2 write odd");
        do_op(OP_W, 0, 0, 16'd0, 1, 0, "R2 read even");
        do_op(OP_W, 0, 0, 16'd1, 1, 0, "R2 read odd");
        do_op(OP_W, 0, 1, 16'd8, 1, 0, "R2 read word4");

        // R3: big-endian byte lanes
        dq[0] = 16'h5678; do_op(OP_W, 1, 0, 16'd2, 1, 0, "R3 setup");
        do_op(OP_B, 0, 1, 16'd3, 1, 0, "R3 odd byte");
        do_op(OP_B, 0, 0, 16'd2, 1, 0, "R3 even byte");

        // R4/R9: flag set, then byte writes keep flag and other byte
        dq[0] = 16'h0001; do_op(OP_F, 1, 1, 16'd1, 5, 0, "R9 flag set");
        dq[0] = 16'h99AB; do_op(OP_B, 1, 0, 16'd3, 1, 0, "R4 byte write low");
        do_op(OP_W, 0, 0, 16'd2, 1, 0, "R4 low merge");
        dq[0] = 16'h00CD; do_op(OP_B, 1, 0, 16'd2, 1, 0, "R4 byte write high");
        do_op(OP_W, 0, 0, 16'd3, 1, 0, "R4 high merge");
        dq[0] = 16'hBEEF; do_op(OP_W, 1, 0, 16'd2, 1, 0, "R4 word write keeps flag");
        do_op(OP_B, 0, 0, 16'd3, 1, 0, "R5 byte read loads flag");
        do_op(OP_F, 0, 1, 16'd1, 3, 0, "R9 flag read");
        dq[0] = 16'h0000; do_op(OP_F, 1, 0, 16'd1, 1, 0, "R9 flag clear");
        do_op(OP_F, 0, 0, 16'd1, 1, 0, "R9 flag read clear");
        do_op(OP_W, 0, 0, 16'd2, 1, 0, "R9 data kept");

        // R6/R7/R8: word strings
        dq[0] = 16'hA001; dq[1] = 16'hA002; dq[2] = 16'hA003; dq[3] = 16'hA004;
        do_op(OP_WS, 1, 1, 16'd16, 4, 0, "R6 word string write");
        dq[0] = 16'h0001; do_op(OP_F, 1, 0, 16'd11, 1, 0, "R7 flag on last");
        do_op(OP_WS, 0, 1, 16'd17, 4, 1, "R7 R11 word string read");
        do_op(OP_WS, 0, 1, 16'd16, 3, 0, "R7 string tag clear");
        do_op(OP_W, 0, 0, 16'd0, 1, 0, "R11 word0 flag untouched");

        // R6/R8: byte strings, both post-mod settings
        dq[0] = 16'h0011; dq[1] = 16'h0022; dq[2] = 16'h0033;
        do_op(OP_BS, 1, 0, 16'd40, 3, 0, "R6 byte string write");
        do_op(OP_BS, 0, 1, 16'd39, 5, 0, "R6 byte string read");
        do_op(OP_BS, 0, 0, 16'd41, 2, 0, "R8 no post-mod");
        do_op(OP_WS, 0, 1, 16'd16, 0, 0, "R6 zero length");

        repeat (3) @(negedge clk);
        chk(q_acc.size() == 0, "R10 all reads seen", 32'(q_acc.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule